// File: doc/BRIEF.md
# Software-Generated Interrupt Router

The router takes a 64-bit software interrupt request that a CPU writes into one of three generation registers. From the written value it extracts a three-level affinity key, a 16-bit target bitmap, a 4-bit interrupt number and a broadcast flag. It then works out the interrupt group from three things: which register was written, whether the writer is secure, and a global security-disable control. It walks a static table of per-CPU affinity values, looking at one CPU per clock, and raises a delivery strobe for every CPU that should receive the interrupt.

Each delivery carries the receiving CPU's index, the resolved group, the interrupt number and the writer's non-secure flag. Redistributor-side permission checks, priority and pending-state storage belong to the receivers and are not part of this block. A request is taken only while the router is idle. When the walk finishes, the router gives a one-cycle completion pulse, even if no CPU matched.

Top module: `sgi_router`

## Requirements
- R1: Write value layout: bits [15:0] are the target bitmap, [23:16] affinity level 1, [27:24] the interrupt number, [39:32] affinity level 2, bit 40 the broadcast flag, [55:48] affinity level 3. Every delivery carries the interrupt number taken from [27:24].
- R2: Each CPU's affinity word is laid out as [31:24] level 3, [23:16] level 2, [15:8] level 1, [7:0] level 0. With the broadcast flag at 0, a CPU is delivered to when its bits [31:8] equal {level 3, level 2, level 1} of the written value and the bitmap bit indexed by its level-0 value is set.
- R3: With the broadcast flag at 0, a CPU whose level-0 affinity is above 15 is never delivered to, whatever the bitmap holds.
- R4: With the broadcast flag at 1, every CPU except the writer (`wr_cpu`) is delivered to, and the affinity and bitmap fields are ignored.
- R5: Register select code 0 produces group code 0 (group 0).
- R6: Register select code 1 produces group code 2 (non-secure group 1) for a non-secure writer and group code 1 (secure group 1) for a secure writer.
- R7: Register select code 2 produces group code 1 for a non-secure writer and group code 2 for a secure writer.
- R8: When `sec_disable` is 1 at the time a write is taken and the resolved group is code 1, the delivered group is code 0. Group code 2 is unaffected.
- R9: Every delivery's non-secure flag equals the inverse of `wr_secure` for the write that was taken.
- R10: A taken write makes `busy` high for exactly NUM_CPU cycles, starting the cycle after the write. In that window the CPUs are examined in ascending index order, one per cycle, and `dlv_cpu` shows the index being examined.
- R11: `done` is high for exactly one cycle, the cycle after the last CPU is examined, and `busy` is low in that cycle. This holds even when no CPU was delivered to.
- R12: A write presented while `busy` is high is dropped without changing the ongoing walk. A write with select code 3 is dropped and starts no walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | A register write is presented this cycle |
| wr_sel | input | 2 | Register select: 0 group 0, 1 group 1, 2 alternate group 1, 3 reserved |
| wr_data | input | 64 | Written value |
| wr_secure | input | 1 | Writer is in the secure state |
| wr_cpu | input | 4 | Index of the writing CPU |
| sec_disable | input | 1 | Security-disable control |
| cpu_aff | input | NUM_CPU*32 | Static affinity word of each CPU, CPU i at [32*i +: 32] |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| dlv_valid | output | 1 | Delivery to CPU `dlv_cpu` this cycle |
| dlv_cpu | output | 4 | Index of the CPU being examined |
| dlv_group | output | 2 | Group code of the delivery |
| dlv_intid | output | 4 | Interrupt number of the delivery |
| dlv_ns | output | 1 | Non-secure flag of the delivery |

## Verification
The bench gives the CPU table one entry that shares the target key but has a level-0 value of 18. A router that indexes the bitmap with truncated low bits would deliver to that CPU when bit 2 of the bitmap is set. It runs broadcasts from different writers; a self-exclusion bug would deliver back to the writer. All three register selects are driven from both security states, with and without security-disable. A swapped group branch or an override that also rewrites non-secure group 1 shows up as a wrong group code. It also checks an empty match, a write presented mid-walk and the reserved select. A broken completion pulse would then be missing, a second walk would start, or a spurious walk would begin.

// File: rtl/sgi_router_pkg.sv
// Package: shared widths, field positions, codes and the decoded request
// record of the software interrupt router.
// Assumes at most 16 CPUs, so a 4-bit CPU index is always enough.
package sgi_router_pkg;

    localparam int CPU_IDX_W = 4;
    localparam int MAX_CPU   = 16;
    localparam int AFF_W     = 32;
    localparam int KEY_W     = 24;
    localparam int TLIST_W   = 16;
    localparam int INTID_W   = 4;
    localparam int WDATA_W   = 64;

    // bit positions inside the written value
    localparam int TLIST_LSB = 0;
    localparam int AFF1_LSB  = 16;
    localparam int INTID_LSB = 24;
    localparam int AFF2_LSB  = 32;
    localparam int BCAST_BIT = 40;
    localparam int AFF3_LSB  = 48;

    typedef enum logic [1:0] {
        GRP_ZERO   = 2'd0,
        GRP_SEC1   = 2'd1,
        GRP_NSEC1  = 2'd2
    } sgi_grp_e;

    typedef enum logic [1:0] {
        SEL_GRP0   = 2'd0,
        SEL_GRP1   = 2'd1,
        SEL_ALT1   = 2'd2,
        SEL_RSVD   = 2'd3
    } sgi_sel_e;

    typedef struct packed {
        logic [KEY_W-1:0]     key;
        logic [TLIST_W-1:0]   tlist;
        logic [INTID_W-1:0]   intid;
        logic                 bcast;
        sgi_grp_e             grp;
        logic                 ns;
        logic [CPU_IDX_W-1:0] src_cpu;
    } sgi_req_t;

    // group from register select, writer state and the override
    function automatic sgi_grp_e resolve_group(input sgi_sel_e sel,
                                               input logic secure,
                                               input logic sec_dis);
        sgi_grp_e g;
        case (sel)
            SEL_GRP1: g = secure ? GRP_SEC1  : GRP_NSEC1;
            SEL_ALT1: g = secure ? GRP_NSEC1 : GRP_SEC1;
            default:  g = GRP_ZERO;
        endcase
        if (sec_dis && (g == GRP_SEC1)) begin
            g = GRP_ZERO;
        end
        return g;
    endfunction

endpackage

// File: rtl/sgi_decode.sv
// Module: sgi_decode
// Splits a written value into a request record and resolves its group.
// Purely combinational; assumes the inputs are stable for the cycle in
// which the write is presented.
module sgi_decode
    import sgi_router_pkg::*;
(
    input  logic [WDATA_W-1:0]   wr_data,
    input  logic [1:0]           wr_sel,
    input  logic                 wr_secure,
    input  logic [CPU_IDX_W-1:0] wr_cpu,
    input  logic                 sec_disable,
    output sgi_req_t             req,
    output logic                 sel_ok
);

    sgi_sel_e sel;

    // map the raw select code onto the select enum
    always_comb begin
        sel = sgi_sel_e'(wr_sel);
    end

    // pull fields out of the written value and fill the record
    always_comb begin
        req.key     = {wr_data[AFF3_LSB +: 8], wr_data[AFF2_LSB +: 8],
                       wr_data[AFF1_LSB +: 8]};
        req.tlist   = wr_data[TLIST_LSB +: TLIST_W];
        req.intid   = wr_data[INTID_LSB +: INTID_W];
        req.bcast   = wr_data[BCAST_BIT];
        req.grp     = resolve_group(sel, wr_secure, sec_disable);
        req.ns      = ~wr_secure;
        req.src_cpu = wr_cpu;
    end

    // only the three defined selects start a walk
    always_comb begin
        sel_ok = (sel != SEL_RSVD);
    end

endmodule

// File: rtl/sgi_target_match.sv
// Module: sgi_target_match
// Decides for every CPU at once whether the held request targets it.
// Combinational; assumes cpu_aff is static while a walk is running.
// Output is padded to MAX_CPU bits so any 4-bit index selects safely.
module sgi_target_match
    import sgi_router_pkg::*;
#(
    parameter int NUM_CPU = 4
)(
    input  sgi_req_t                   req,
    input  logic [NUM_CPU*AFF_W-1:0]   cpu_aff,
    output logic [MAX_CPU-1:0]         hit
);

    logic [NUM_CPU-1:0] hit_n;

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
        logic [AFF_W-1:0] aff;
        logic             tgt_hit;
        logic             bc_hit;

        // pick this CPU's affinity word
        always_comb begin
            aff = cpu_aff[i*AFF_W +: AFF_W];
        end

        // targeted mode: key match, level 0 in range, bitmap bit set
        always_comb begin
            tgt_hit = (aff[AFF_W-1:8] == req.key) &&
                      (aff[7:0] < 8'(TLIST_W)) &&
                      req.tlist[aff[3:0]];
        end

        // broadcast mode: everyone but the writer
        always_comb begin
            bc_hit = (CPU_IDX_W'(i) != req.src_cpu);
        end

        // choose by routing mode
        always_comb begin
            hit_n[i] = req.bcast ? bc_hit : tgt_hit;
        end
    end

    // pad to the full index range
    always_comb begin
        hit = '0;
        hit[NUM_CPU-1:0] = hit_n;
    end

endmodule

// File: rtl/sgi_scan_ctrl.sv
// Module: sgi_scan_ctrl
// Holds the taken request and steps a CPU index from 0 to NUM_CPU-1,
// one per cycle, then raises done for one cycle.
// Assumes start is only raised while busy is low.
module sgi_scan_ctrl
    import sgi_router_pkg::*;
#(
    parameter int NUM_CPU = 4
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  sgi_req_t             req_in,
    output sgi_req_t             req_q,
    output logic [CPU_IDX_W-1:0] idx,
    output logic                 busy,
    output logic                 done
);

    localparam logic [CPU_IDX_W-1:0] LAST_IDX = CPU_IDX_W'(NUM_CPU - 1);

    // capture a request, walk the index, flag completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
            idx   <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                req_q <= req_in;
                idx   <= '0;
                busy  <= 1'b1;
            end else if (busy) begin
                if (idx == LAST_IDX) begin
                    idx  <= '0;
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sgi_router.sv
// Module: sgi_router (top)
// Takes a software interrupt generation write while idle, then examines
// one CPU per cycle in ascending order and strobes a delivery for each
// targeted CPU. Assumes 1 <= NUM_CPU <= 16 and a static cpu_aff table.
module sgi_router
    import sgi_router_pkg::*;
#(
    parameter int NUM_CPU = 4
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_valid,
    input  logic [1:0]                 wr_sel,
    input  logic [WDATA_W-1:0]         wr_data,
    input  logic                       wr_secure,
    input  logic [CPU_IDX_W-1:0]       wr_cpu,
    input  logic                       sec_disable,
    input  logic [NUM_CPU*AFF_W-1:0]   cpu_aff,
    output logic                       busy,
    output logic                       done,
    output logic                       dlv_valid,
    output logic [CPU_IDX_W-1:0]       dlv_cpu,
    output logic [1:0]                 dlv_group,
    output logic [INTID_W-1:0]         dlv_intid,
    output logic                       dlv_ns
);

    sgi_req_t             req_new;
    sgi_req_t             req_q;
    logic                 sel_ok;
    logic                 start;
    logic [CPU_IDX_W-1:0] idx;
    logic [MAX_CPU-1:0]   hit;

    sgi_decode u_decode (
        .wr_data     (wr_data),
        .wr_sel      (wr_sel),
        .wr_secure   (wr_secure),
        .wr_cpu      (wr_cpu),
        .sec_disable (sec_disable),
        .req         (req_new),
        .sel_ok      (sel_ok)
    );

    // a write is taken only when idle and the select is defined
    always_comb begin
        start = wr_valid && !busy && sel_ok;
    end

    sgi_scan_ctrl #(.NUM_CPU(NUM_CPU)) u_scan (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .req_in (req_new),
        .req_q  (req_q),
        .idx    (idx),
        .busy   (busy),
        .done   (done)
    );

    sgi_target_match #(.NUM_CPU(NUM_CPU)) u_match (
        .req     (req_q),
        .cpu_aff (cpu_aff),
        .hit     (hit)
    );

    // present the examined CPU and its delivery fields
    always_comb begin
        dlv_valid = busy && hit[idx];
        dlv_cpu   = idx;
        dlv_group = req_q.grp;
        dlv_intid = req_q.intid;
        dlv_ns    = req_q.ns;
    end

endmodule

// File: rtl/sgi_router_chk.sv
// Module: sgi_router_chk
// Temporal checks on the router's ports and held request; attached to
// every sgi_router instance by the bind below.
module sgi_router_chk
    import sgi_router_pkg::*;
#(
    parameter int NUM_CPU = 4
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 busy,
    input  logic                 done,
    input  logic                 dlv_valid,
    input  logic [CPU_IDX_W-1:0] dlv_cpu,
    input  logic [1:0]           dlv_group,
    input  logic [INTID_W-1:0]   dlv_intid,
    input  logic                 dlv_ns,
    input  logic                 held_bcast,
    input  logic [CPU_IDX_W-1:0] held_src
);

    localparam logic [CPU_IDX_W-1:0] LAST_IDX = CPU_IDX_W'(NUM_CPU - 1);

    // R10
    dlv_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> busy);

    // R10
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dlv_cpu != LAST_IDX) |=> (busy && dlv_cpu == $past(dlv_cpu) + 1'b1));

    // R11
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dlv_cpu == LAST_IDX) |=> (done && !busy));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    no_self_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && held_bcast) |-> (dlv_cpu != held_src));

    // R12
    walk_fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(dlv_intid) && $stable(dlv_group) && $stable(dlv_ns)));

    // R5
    group_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> (dlv_group != 2'd3));

endmodule

bind sgi_router sgi_router_chk #(.NUM_CPU(NUM_CPU)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .dlv_valid  (dlv_valid),
    .dlv_cpu    (dlv_cpu),
    .dlv_group  (dlv_group),
    .dlv_intid  (dlv_intid),
    .dlv_ns     (dlv_ns),
    .held_bcast (req_q.bcast),
    .held_src   (req_q.src_cpu)
);

// File: tb/sgi_router_tb.sv
`timescale 1ns/1ps
// Bench for sgi_router: vector table walked by one loop, then directed
// tests for reset, mid-walk writes and the reserved select.
module sgi_router_tb;

    localparam int NUM_CPU = 4;

    typedef struct packed {
        logic [1:0]  sel;
        logic        sec;
        logic [3:0]  cpu;
        logic        sd;
        logic [63:0] data;
        logic [3:0]  mask;
        logic [1:0]  grp;
    } vec_t;

    // data layout: 00_A3_0B_A2_0I_A1_TTTT (B broadcast, I intid)
    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{2'd1, 1'b0, 4'd0, 1'b0, 64'h0001_0002_0503_0021, 4'b0011, 2'd2},
        '{2'd1, 1'b1, 4'd0, 1'b0, 64'h0001_0002_0903_FFFF, 4'b0011, 2'd1},
        '{2'd2, 1'b0, 4'd2, 1'b0, 64'h0000_0100_0300_0000, 4'b1011, 2'd1},
        '{2'd2, 1'b1, 4'd0, 1'b0, 64'h0000_0100_0F00_0000, 4'b1110, 2'd2},
        '{2'd0, 1'b1, 4'd1, 1'b0, 64'h0001_0002_0004_0002, 4'b0100, 2'd0},
        '{2'd1, 1'b1, 4'd3, 1'b1, 64'h0000_0100_0700_0000, 4'b0111, 2'd0},
        '{2'd1, 1'b0, 4'd1, 1'b1, 64'h0001_0002_0C03_0001, 4'b0001, 2'd2},
        '{2'd0, 1'b0, 4'd0, 1'b0, 64'h0009_0009_0409_FFFF, 4'b0000, 2'd0},
        '{2'd2, 1'b0, 4'd0, 1'b1, 64'h0001_0002_0A03_0020, 4'b0010, 2'd0}
    };

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   wr_valid = 1'b0;
    logic [1:0]             wr_sel = '0;
    logic [63:0]            wr_data = '0;
    logic                   wr_secure = 1'b0;
    logic [3:0]             wr_cpu = '0;
    logic                   sec_disable = 1'b0;
    logic [NUM_CPU*32-1:0]  cpu_aff;
    logic                   busy, done, dlv_valid, dlv_ns;
    logic [3:0]             dlv_cpu, dlv_intid;
    logic [1:0]             dlv_group;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // CPU3 shares the key of CPU0/1 but has level 0 = 18
    assign cpu_aff = {32'h0102_0312, 32'h0102_0401, 32'h0102_0305, 32'h0102_0300};

    always #4 clk = ~clk;

    sgi_router #(.NUM_CPU(NUM_CPU)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sel(wr_sel),
        .wr_data(wr_data), .wr_secure(wr_secure), .wr_cpu(wr_cpu),
        .sec_disable(sec_disable), .cpu_aff(cpu_aff), .busy(busy),
        .done(done), .dlv_valid(dlv_valid), .dlv_cpu(dlv_cpu),
        .dlv_group(dlv_group), .dlv_intid(dlv_intid), .dlv_ns(dlv_ns)
    );

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic present(input logic [1:0] sel, input logic sec, input logic [3:0] cpu,
                           input logic sd, input logic [63:0] data);
        @(negedge clk);
        wr_valid = 1'b1; wr_sel = sel; wr_secure = sec;
        wr_cpu = cpu; sec_disable = sd; wr_data = data;
    endtask

    // walk one vector: take the write, collect deliveries, check completion
    task automatic run_vec(input int n, input vec_t v);
        logic [3:0] got;
        string rt, gt;
        got = '0;
        rt = v.data[40] ? "R4" : "R2/R3";
        gt = v.sd ? "R8" : (v.sel == 2'd0 ? "R5" : (v.sel == 2'd1 ? "R6" : "R7"));
        present(v.sel, v.sec, v.cpu, v.sd, v.data);
        @(negedge clk);
        wr_valid = 1'b0;
        for (int k = 0; k < NUM_CPU; k++) begin
            if (k > 0) @(negedge clk);
            chk($sformatf("R10 busy v%0d k%0d", n, k), 64'(busy), 64'd1);
            chk($sformatf("R10 order v%0d k%0d", n, k), 64'(dlv_cpu), 64'(k));
            if (dlv_valid) begin
                got[k] = 1'b1;
                chk($sformatf("%s group v%0d", gt, n), 64'(dlv_group), 64'(v.grp));
                chk($sformatf("R1 intid v%0d", n), 64'(dlv_intid), 64'(v.data[27:24]));
                chk($sformatf("R9 ns v%0d", n), 64'(dlv_ns), 64'(!v.sec));
            end
        end
        chk($sformatf("%s targets v%0d", rt, n), 64'(got), 64'(v.mask));
        @(negedge clk);
        chk($sformatf("R11 done v%0d", n), 64'({done, busy}), 64'b10);
        @(negedge clk);
        chk($sformatf("R11 done once v%0d", n), 64'(done), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        chk("R10 reset busy/done/valid", 64'({busy, done, dlv_valid}), 64'd0);
        rst_n = 1'b1;

        for (int n = 0; n < NVEC; n++) begin
            run_vec(n, VECS[n]);
        end

        // R12: write during a walk is dropped
        begin
            logic [3:0] got;
            got = '0;
            present(2'd0, 1'b1, 4'd0, 1'b0, 64'h0000_0100_0600_0000);
            @(negedge clk);
            wr_data = 64'h0001_0002_0B03_0001;
            wr_sel = 2'd1;
            for (int k = 0; k < NUM_CPU; k++) begin
                if (k > 0) @(negedge clk);
                wr_valid = (k < 2);
                if (dlv_valid) begin
                    got[k] = 1'b1;
                    chk("R12 intid kept", 64'(dlv_intid), 64'd6);
                end
            end
            wr_valid = 1'b0;
            chk("R12 targets kept", 64'(got), 64'b1110);
            @(negedge clk);
            chk("R12 done", 64'({done, busy}), 64'b10);
            @(negedge clk);
            chk("R12 no second walk", 64'({busy, dlv_valid, done}), 64'd0);
        end

        // R12: reserved select starts nothing
        present(2'd3, 1'b0, 4'd0, 1'b0, 64'h0000_0100_0500_0000);
        @(negedge clk);
        wr_valid = 1'b0;
        for (int k = 0; k < NUM_CPU + 2; k++) begin
            chk("R12 reserved select idle", 64'({busy, dlv_valid, done}), 64'd0);
            @(negedge clk);
        end

        // reset mid-walk returns to idle
        present(2'd0, 1'b0, 4'd1, 1'b0, 64'h0000_0100_0100_0000);
        @(negedge clk);
        wr_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 reset during walk", 64'({busy, done, dlv_valid}), 64'd0);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule